// File: doc/BRIEF.md
# Receive Offset Calibration and Power Sequencer

This controller removes the DC offset from a two-channel (I and Q) receive sample stream and sequences power to the converter sections. Each sample arrives tagged with its channel and leaves one cycle later. On the way out, that channel's offset register is subtracted from it and the result is clamped to the 15-bit signed range. Software may load either offset register directly. The block can also measure the offsets itself.

A self-measurement begins only while the auto-calibration enable is high. It runs two programmable settling waits, one after the other. It then averages a fixed number of samples per channel and loads the averages into the offset registers. A mode input picks internal measurement or external measurement. Internal measurement asks the front end to short its differential inputs. External measurement leaves the inputs connected, so system offset is captured too. Samples emitted during the measurement window are marked as not usable.

The power side decodes the separate ADC and DAC power-down controls. It also decodes a low-power mode that turns off both converters while the reference stays up. When the converters and the reference are all down, the master clock enable drops after a fixed delay.

Top module: `rxcal_power_seq`

## Requirements
- R1: After reset, `cal_busy`, `short_inputs` and `out_valid` are 0, `mclk_en` is 1, and both offset registers hold 0, so the first sample leaves unchanged.
- R2: A `cal_go` pulse is accepted only while `autocal_en` is 1. With `autocal_en` at 0 it has no effect and `cal_busy` stays 0.
- R3: `cal_busy` rises on the edge that accepts `cal_go`, with `dly1_cfg` and `dly2_cfg` captured there. Counting that edge as 0, samples taken at edges 1 through `dly1_cfg+dly2_cfg+2` pass normally (`out_stale`=0) and are not measured.
- R4: From edge `dly1_cfg+dly2_cfg+3` until the offsets are loaded, every sample leaves with `out_stale`=1, still corrected by the old offset.
- R5: While busy, `short_inputs` is 1 when the request was made with `cal_ext`=0 (internal) and 0 when made with `cal_ext`=1 (external). It is 0 when idle.
- R6: During measurement, the first 16 samples of each channel (`in_iq`=0 is I, 1 is Q) are summed. Further samples of a full channel are ignored. On the edge after both channels are full, each offset is loaded with floor(sum/16) and `cal_busy` falls.
- R7: For every sample, on the next edge `out_valid`=1, `out_iq` equals `in_iq`, and `out_data` = in_data − offset[in_iq], saturated to −16384..16383. With no sample, `out_valid` is 0.
- R8: `usr_wr` loads `usr_off` into the I offset (`usr_sel`=0) or the Q offset (`usr_sel`=1). The new value applies to samples from the next edge on.
- R9: One edge after the inputs: `adc_on` = not(`adc_pd` or `low_pwr`), `dac_on` = not(`dac_pd` or `low_pwr`), `ref_on` = not `ref_pd`. Low-power mode leaves the reference on.
- R10: `mclk_en` falls on the 64th consecutive edge at which ADC, DAC and reference are all down. It returns to 1 on the first edge at which any of them is up.
- R11: A `cal_go` received while busy is ignored, so the running sequence keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| autocal_en | input | 1 | Auto-calibration enable |
| cal_go | input | 1 | Calibration request pulse |
| cal_ext | input | 1 | Measurement mode: 0 internal (shorted), 1 external |
| dly1_cfg | input | 8 | First settling wait length |
| dly2_cfg | input | 8 | Second settling wait length |
| in_valid | input | 1 | Sample strobe |
| in_iq | input | 1 | Sample channel, 0 = I, 1 = Q |
| in_data | input | 15 | Raw sample, two's complement |
| usr_wr | input | 1 | Direct offset write strobe |
| usr_sel | input | 1 | Offset register to write, 0 = I, 1 = Q |
| usr_off | input | 15 | Offset value to write |
| adc_pd | input | 1 | ADC power-down |
| dac_pd | input | 1 | DAC power-down |
| low_pwr | input | 1 | Low-power mode, converters off, reference on |
| ref_pd | input | 1 | Reference power-down |
| out_valid | output | 1 | Corrected sample strobe |
| out_iq | output | 1 | Corrected sample channel |
| out_data | output | 15 | Corrected, saturated sample |
| out_stale | output | 1 | Sample taken during the measurement window |
| cal_busy | output | 1 | Calibration in progress |
| short_inputs | output | 1 | Front end asked to short its inputs |
| adc_on | output | 1 | ADC power enable |
| dac_on | output | 1 | DAC power enable |
| ref_on | output | 1 | Reference power enable |
| mclk_en | output | 1 | Master clock enable |

## Verification
The hardest moment to reach is the single edge where the second settling wait expires. Just as hard is the edge where both channels become full and the offsets load while a sample is still arriving. The stimulus counts edges from the accepted request and keeps a sample on the input every cycle, so both boundaries are hit exactly. A repeated request in the middle of the first wait shows that the timing is not restarted. A full-channel surplus sample and a large sample at the loading edge show that neither leaks into the averages.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;
  localparam int NCH  = 2;
  localparam int CH_I = 0;
  localparam int CH_Q = 1;

  typedef enum logic [1:0] {
    CAL_IDLE,
    CAL_WAIT1,
    CAL_WAIT2,
    CAL_MEAS
  } cal_state_e;
endpackage

// File: rtl/rxcal_seq.sv
module rxcal_seq
  import rxcal_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_go,
  input  logic             autocal_en,
  input  logic             cal_ext,
  input  logic [DLY_W-1:0] dly1,
  input  logic [DLY_W-1:0] dly2,
  input  logic             acc_full,
  output logic             start,
  output logic             commit,
  output logic             busy,
  output logic             meas,
  output logic             short_in
);
  cal_state_e       state;
  logic [DLY_W-1:0] tmr;
  logic [DLY_W-1:0] dly2_q;
  logic             ext_q;

  assign start  = (state == CAL_IDLE) && cal_go && autocal_en;
  assign commit = (state == CAL_MEAS) && acc_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CAL_IDLE;
      tmr      <= '0;
      dly2_q   <= '0;
      ext_q    <= 1'b0;
      busy     <= 1'b0;
      meas     <= 1'b0;
      short_in <= 1'b0;
    end else begin
      case (state)
        CAL_IDLE: begin
          if (start) begin
            state    <= CAL_WAIT1;
            tmr      <= dly1;
            dly2_q   <= dly2;
            ext_q    <= cal_ext;
            busy     <= 1'b1;
            short_in <= !cal_ext;
          end
        end
        CAL_WAIT1: begin
          if (tmr == '0) begin
            state <= CAL_WAIT2;
            tmr   <= dly2_q;
          end else begin
            tmr <= tmr - DLY_W'(1);
          end
        end
        CAL_WAIT2: begin
          if (tmr == '0) begin
            state <= CAL_MEAS;
            meas  <= 1'b1;
          end else begin
            tmr <= tmr - DLY_W'(1);
          end
        end
        default: begin
          if (acc_full) begin
            state    <= CAL_IDLE;
            busy     <= 1'b0;
            meas     <= 1'b0;
            short_in <= 1'b0;
          end
        end
      endcase
    end
  end

  // R5
  short_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(short_in) && (short_in == !ext_q)));
  // R6
  commit_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy && !meas);
  // R3
  start_waits_first_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && !meas);
  // R11
  go_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit) |=> busy);
endmodule

// File: rtl/rxcal_avg.sv
module rxcal_avg #(
  parameter int W    = 15,
  parameter int NAVG = 16,
  parameter int CH   = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         meas,
  input  logic         in_valid,
  input  logic         in_iq,
  input  logic [W-1:0] in_data,
  output logic         full,
  output logic [W-1:0] avg
);
  localparam int LOG2 = $clog2(NAVG);
  localparam int SW   = W + LOG2;
  localparam int CW   = $clog2(NAVG + 1);

  logic [CW-1:0] cnt;
  logic [SW-1:0] sum;
  logic          take;

  assign full = (cnt == CW'(NAVG));
  assign avg  = sum[SW-1:LOG2];
  assign take = meas && in_valid && (in_iq == 1'(CH)) && !full;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      sum <= '0;
    end else if (take) begin
      cnt <= cnt + CW'(1);
      sum <= sum + {{LOG2{in_data[W-1]}}, in_data};
    end
  end

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(NAVG));
  // R6
  full_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !clear) |=> full && $stable(sum));
endmodule

// File: rtl/rxcal_offsub.sv
module rxcal_offsub
  import rxcal_pkg::*;
#(
  parameter int W = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit,
  input  logic [NCH-1:0][W-1:0]   avg,
  input  logic                    usr_wr,
  input  logic                    usr_sel,
  input  logic [W-1:0]            usr_off,
  input  logic                    meas,
  input  logic                    in_valid,
  input  logic                    in_iq,
  input  logic [W-1:0]            in_data,
  output logic                    out_valid,
  output logic                    out_iq,
  output logic [W-1:0]            out_data,
  output logic                    out_stale
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [NCH-1:0][W-1:0] off_r;
  logic [W:0]            diff;
  logic [W-1:0]          clamped;

  for (genvar g = 0; g < NCH; g++) begin : g_off
    always_ff @(posedge clk) begin
      if (rst) begin
        off_r[g] <= '0;
      end else if (commit) begin
        off_r[g] <= avg[g];
      end else if (usr_wr && (usr_sel == 1'(g))) begin
        off_r[g] <= usr_off;
      end
    end
  end

  always_comb begin
    diff = {in_data[W-1], in_data} - {off_r[in_iq][W-1], off_r[in_iq]};
    if (diff[W] != diff[W-1]) begin
      clamped = diff[W] ? SMIN : SMAX;
    end else begin
      clamped = diff[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_iq    <= 1'b0;
      out_data  <= '0;
      out_stale <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_stale <= in_valid && meas;
      if (in_valid) begin
        out_iq   <= in_iq;
        out_data <= clamped;
      end
    end
  end

  // R7
  sample_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid && (out_iq == $past(in_iq)));
  // R7
  no_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4
  stale_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_stale |-> out_valid);
endmodule

// File: rtl/rxcal_pwr.sv
module rxcal_pwr #(
  parameter int GATE_DLY = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic adc_pd,
  input  logic dac_pd,
  input  logic low_pwr,
  input  logic ref_pd,
  output logic adc_on,
  output logic dac_on,
  output logic ref_on,
  output logic mclk_en
);
  localparam int CW = $clog2(GATE_DLY + 1);

  logic [CW-1:0] idle_cnt;
  logic          adc_down;
  logic          dac_down;
  logic          all_down;

  assign adc_down = adc_pd || low_pwr;
  assign dac_down = dac_pd || low_pwr;
  assign all_down = adc_down && dac_down && ref_pd;

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_on <= 1'b0;
      dac_on <= 1'b0;
      ref_on <= 1'b0;
    end else begin
      adc_on <= !adc_down;
      dac_on <= !dac_down;
      ref_on <= !ref_pd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      mclk_en  <= 1'b1;
    end else if (!all_down) begin
      idle_cnt <= '0;
      mclk_en  <= 1'b1;
    end else begin
      if (idle_cnt != CW'(GATE_DLY)) begin
        idle_cnt <= idle_cnt + CW'(1);
      end
      if (idle_cnt == CW'(GATE_DLY - 1)) begin
        mclk_en <= 1'b0;
      end
    end
  end

  // R9
  low_power_keeps_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (low_pwr && !ref_pd) |=> !adc_on && !dac_on && ref_on);
  // R10
  gate_only_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mclk_en) |-> (!adc_on && !dac_on && !ref_on));
  // R10
  wake_restores_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_pd |=> mclk_en);
endmodule

// File: rtl/rxcal_power_seq.sv
module rxcal_power_seq
  import rxcal_pkg::*;
#(
  parameter int W        = 15,
  parameter int DLY_W    = 8,
  parameter int NAVG     = 16,
  parameter int GATE_DLY = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             autocal_en,
  input  logic             cal_go,
  input  logic             cal_ext,
  input  logic [DLY_W-1:0] dly1_cfg,
  input  logic [DLY_W-1:0] dly2_cfg,
  input  logic             in_valid,
  input  logic             in_iq,
  input  logic [W-1:0]     in_data,
  input  logic             usr_wr,
  input  logic             usr_sel,
  input  logic [W-1:0]     usr_off,
  input  logic             adc_pd,
  input  logic             dac_pd,
  input  logic             low_pwr,
  input  logic             ref_pd,
  output logic             out_valid,
  output logic             out_iq,
  output logic [W-1:0]     out_data,
  output logic             out_stale,
  output logic             cal_busy,
  output logic             short_inputs,
  output logic             adc_on,
  output logic             dac_on,
  output logic             ref_on,
  output logic             mclk_en
);
  logic                  start;
  logic                  commit;
  logic                  meas;
  logic [NCH-1:0]        full_vec;
  logic [NCH-1:0][W-1:0] avg_vec;

  rxcal_seq #(.DLY_W(DLY_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cal_go     (cal_go),
    .autocal_en (autocal_en),
    .cal_ext    (cal_ext),
    .dly1       (dly1_cfg),
    .dly2       (dly2_cfg),
    .acc_full   (&full_vec),
    .start      (start),
    .commit     (commit),
    .busy       (cal_busy),
    .meas       (meas),
    .short_in   (short_inputs)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_avg
    rxcal_avg #(.W(W), .NAVG(NAVG), .CH(c)) u_avg (
      .clk      (clk),
      .rst      (rst),
      .clear    (start),
      .meas     (meas),
      .in_valid (in_valid),
      .in_iq    (in_iq),
      .in_data  (in_data),
      .full     (full_vec[c]),
      .avg      (avg_vec[c])
    );
  end

  rxcal_offsub #(.W(W)) u_offsub (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .avg       (avg_vec),
    .usr_wr    (usr_wr),
    .usr_sel   (usr_sel),
    .usr_off   (usr_off),
    .meas      (meas),
    .in_valid  (in_valid),
    .in_iq     (in_iq),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_iq    (out_iq),
    .out_data  (out_data),
    .out_stale (out_stale)
  );

  rxcal_pwr #(.GATE_DLY(GATE_DLY)) u_pwr (
    .clk     (clk),
    .rst     (rst),
    .adc_pd  (adc_pd),
    .dac_pd  (dac_pd),
    .low_pwr (low_pwr),
    .ref_pd  (ref_pd),
    .adc_on  (adc_on),
    .dac_on  (dac_on),
    .ref_on  (ref_on),
    .mclk_en (mclk_en)
  );

  // R2
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!cal_busy && !autocal_en) |=> !cal_busy);
endmodule

// File: tb/rxcal_power_seq_bench.sv
`timescale 1ns/1ps
module rxcal_power_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        autocal_en = 1'b0, cal_go = 1'b0, cal_ext = 1'b0;
  logic [7:0]  dly1_cfg = '0, dly2_cfg = '0;
  logic        in_valid = 1'b0, in_iq = 1'b0;
  logic [14:0] in_data = '0;
  logic        usr_wr = 1'b0, usr_sel = 1'b0;
  logic [14:0] usr_off = '0;
  logic        adc_pd = 1'b0, dac_pd = 1'b0, low_pwr = 1'b0, ref_pd = 1'b0;
  logic        out_valid, out_iq, out_stale, cal_busy, short_inputs;
  logic        adc_on, dac_on, ref_on, mclk_en;
  logic [14:0] out_data;

  int vectors = 0;
  int miscompares = 0;
  int offi = 0;
  int offq = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rxcal_power_seq u_rxcal_power_seq (
    .clk(clk), .rst(rst), .autocal_en(autocal_en), .cal_go(cal_go),
    .cal_ext(cal_ext), .dly1_cfg(dly1_cfg), .dly2_cfg(dly2_cfg),
    .in_valid(in_valid), .in_iq(in_iq), .in_data(in_data),
    .usr_wr(usr_wr), .usr_sel(usr_sel), .usr_off(usr_off),
    .adc_pd(adc_pd), .dac_pd(dac_pd), .low_pwr(low_pwr), .ref_pd(ref_pd),
    .out_valid(out_valid), .out_iq(out_iq), .out_data(out_data),
    .out_stale(out_stale), .cal_busy(cal_busy), .short_inputs(short_inputs),
    .adc_on(adc_on), .dac_on(dac_on), .ref_on(ref_on), .mclk_en(mclk_en)
  );

  function automatic int sat_sub(int a, int b);
    int d = a - b;
    if (d > 16383) return 16383;
    if (d < -16384) return -16384;
    return d;
  endfunction

  function automatic int sv(logic [14:0] x);
    return int'($signed(x));
  endfunction

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom_range(0, hi - lo));
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(logic iq, int v, int stale, string tag);
    in_valid = 1'b1;
    in_iq    = iq;
    in_data  = v[14:0];
    tick();
    in_valid = 1'b0;
    check({tag, " data"}, sv(out_data), sat_sub(v, iq ? offq : offi));
    check({tag, " stale"}, int'(out_stale), stale);
    check({tag, " iq"}, int'(out_iq), int'(iq));
    check({tag, " valid"}, int'(out_valid), 1);
  endtask

  task automatic uwrite(logic sel, int v);
    usr_wr  = 1'b1;
    usr_sel = sel;
    usr_off = v[14:0];
    tick();
    usr_wr = 1'b0;
    if (sel) offq = v; else offi = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual unfinished expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int si, sq, v;
    void'($urandom(32'd4242));
    repeat (4) tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 busy", int'(cal_busy), 0);
    check("R1 short", int'(short_inputs), 0);
    check("R1 valid", int'(out_valid), 0);
    check("R1 mclk", int'(mclk_en), 1);
    send(1'b0, 1234, 0, "R1");
    send(1'b1, -777, 0, "R1");
    tick();
    check("R7 idle valid", int'(out_valid), 0);

    // R2 request ignored while auto-calibration disabled
    autocal_en = 1'b0; cal_go = 1'b1;
    tick();
    cal_go = 1'b0;
    repeat (3) tick();
    check("R2 busy", int'(cal_busy), 0);

    // R8 / R7 directed saturation corners
    uwrite(1'b0, -16384);
    send(1'b0, 16383, 0, "R7 sat hi");
    uwrite(1'b1, 16383);
    send(1'b1, -16384, 0, "R7 sat lo");
    send(1'b1, 0, 0, "R8 q off");
    send(1'b0, -16384, 0, "R8 i off");

    // R8 / R7 random offsets and samples
    for (int n = 0; n < 150; n++) begin
      if ($urandom_range(0, 3) == 0) uwrite(1'($urandom_range(0, 1)), rnd(-16384, 16383));
      if ($urandom_range(0, 4) == 0) begin
        tick();
        check("R7 gap valid", int'(out_valid), 0);
      end
      send(1'($urandom_range(0, 1)), rnd(-16384, 16383), 0, "R7 rand");
    end

    // Internal calibration, dly1=3 dly2=5
    uwrite(1'b0, 40);
    uwrite(1'b1, -25);
    autocal_en = 1'b1; cal_ext = 1'b0; dly1_cfg = 8'd3; dly2_cfg = 8'd5;
    cal_go = 1'b1;
    tick();
    cal_go = 1'b0;
    check("R3 busy rise", int'(cal_busy), 1);
    check("R5 short internal", int'(short_inputs), 1);
    for (int j = 1; j <= 10; j++) begin
      if (j == 2) cal_go = 1'b1;   // R11 repeat request mid-wait
      send(1'b0, 9000 + j, 0, "R3 R11 settle");
      cal_go = 1'b0;
    end
    si = 0; sq = 0;
    for (int k = 0; k < 32; k++) begin
      v = rnd(-3000, 3000);
      if (k % 2 == 1) sq += v; else si += v;
      send(1'(k % 2), v, 1, "R4 meas");
    end
    check("R6 busy before load", int'(cal_busy), 1);
    send(1'b0, 16000, 1, "R4 load edge");
    check("R6 busy after load", int'(cal_busy), 0);
    check("R5 short idle", int'(short_inputs), 0);
    offi = si >>> 4; offq = sq >>> 4;
    send(1'b0, 500, 0, "R6 new I");
    send(1'b1, -500, 0, "R6 new Q");

    // External calibration, zero waits, surplus sample ignored
    cal_ext = 1'b1; dly1_cfg = 8'd0; dly2_cfg = 8'd0;
    cal_go = 1'b1;
    tick();
    cal_go = 1'b0;
    check("R5 short external", int'(short_inputs), 0);
    check("R3 busy ext", int'(cal_busy), 1);
    send(1'b1, 12000, 0, "R3 ext settle");
    send(1'b0, -12000, 0, "R3 ext settle");
    si = 0; sq = 0;
    for (int k = 0; k < 16; k++) begin
      v = rnd(-8000, 8000); sq += v;
      send(1'b1, v, 1, "R4 ext Q");
    end
    send(1'b1, 15000, 1, "R6 surplus Q");
    for (int k = 0; k < 16; k++) begin
      v = rnd(-8000, 8000); si += v;
      send(1'b0, v, 1, "R4 ext I");
    end
    tick();
    check("R6 ext busy", int'(cal_busy), 0);
    offi = si >>> 4; offq = sq >>> 4;
    for (int n = 0; n < 20; n++) send(1'($urandom_range(0, 1)), rnd(-16384, 16383), 0, "R6 ext apply");

    // R9 power decode
    adc_pd = 1'b1;
    tick();
    check("R9 adc off", int'(adc_on), 0);
    check("R9 dac on", int'(dac_on), 1);
    check("R9 ref on", int'(ref_on), 1);
    adc_pd = 1'b0; low_pwr = 1'b1;
    tick();
    check("R9 lp adc", int'(adc_on), 0);
    check("R9 lp dac", int'(dac_on), 0);
    check("R9 lp ref", int'(ref_on), 1);
    repeat (70) tick();
    check("R10 lp clk kept", int'(mclk_en), 1);

    // R10 gating after 64 edges, all down through explicit bits
    low_pwr = 1'b0; adc_pd = 1'b1; dac_pd = 1'b1; ref_pd = 1'b1;
    repeat (63) tick();
    check("R10 edge 63", int'(mclk_en), 1);
    tick();
    check("R10 edge 64", int'(mclk_en), 0);
    check("R9 ref off", int'(ref_on), 0);
    ref_pd = 1'b0;
    tick();
    check("R10 wake", int'(mclk_en), 1);

    // R10 low-power plus reference off also counts as all down
    adc_pd = 1'b0; dac_pd = 1'b0; low_pwr = 1'b1; ref_pd = 1'b1;
    repeat (64) tick();
    check("R10 lp gate", int'(mclk_en), 0);
    low_pwr = 1'b0;
    tick();
    check("R10 lp wake", int'(mclk_en), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule